// File: doc/BRIEF.md
# Bridge I/O Window Forwarding Decoder

This block decides, for each I/O transaction reaching a two-sided bus bridge, whether the bridge should pass it across. Software programs a 4 KB-granular window with a base page and an inclusive limit page over the 16-bit I/O space, plus an I/O enable bit and an ISA alias-filter bit, through a small write port. Each transaction presents an address and a direction flag. Downstream means primary side to secondary side. Upstream means secondary side to primary side. One clock later the block reports the forward decision.

Addresses claimed downstream are those inside an enabled, non-empty window. Upstream forwarding is the exact complement of that claim. With the ISA filter on, only the low 256 bytes of each naturally aligned 1 KB block inside the window stay claimed for the secondary side. The upper 768 bytes of each such block are sent upstream instead. The filter leaves addresses outside the window untouched.

Top module: `ioWindowDecoder`

## Requirements
- R1: After reset the base page is 0xF, the limit page is 0x0, and both enable bits are 0. In this state no downstream transaction is forwarded and every upstream transaction is forwarded.
- R2: A write with cfgWrEn high selects a target with cfgSel. cfgSel=0 loads the base page and cfgSel=1 loads the limit page, each from cfgWrData[3:0]. cfgSel=2 loads ioEnable from bit 0 and isaFilter from bit 1. cfgSel=3 changes no state.
- R3: When the limit page is below the base page, no downstream transaction is forwarded and every upstream one is forwarded.
- R4: While ioEnable is 0, no downstream transaction is forwarded.
- R5: decValid is high exactly in the cycle after a cycle with reqValid high. decForward is 0 whenever decValid is 0.
- R6: With isaFilter clear, a downstream transaction is forwarded exactly when ioEnable is 1 and base <= addr[15:12] <= limit. The limit covers offsets up to 0xFFF of its page.
- R7: With isaFilter set, a downstream address inside the window is forwarded only when addr[9:8] is 00.
- R8: An upstream transaction is forwarded exactly when the same address would not be forwarded downstream. This includes in-window addresses with addr[9:8] nonzero while isaFilter is set.
- R9: For addresses outside the window, the decision is the same whether isaFilter is set or clear.
- R10: A register write in the same cycle as a request strobe affects only later strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgSel | input | 2 | Register select: 0 base, 1 limit, 2 enables, 3 unused |
| cfgWrData | input | 4 | Write data |
| reqValid | input | 1 | Transaction address strobe |
| reqUpstream | input | 1 | 1 = secondary to primary, 0 = primary to secondary |
| reqAddr | input | 16 | I/O address |
| decValid | output | 1 | Decision valid, one cycle after reqValid |
| decForward | output | 1 | 1 = forward the transaction across the bridge |

## Verification
The bench builds the block with its default parameters: a 16-bit address, a 4-bit page field and a 1 KB alias block with a 2-bit alias index. With these values every page boundary and every alias sub-range of the whole I/O space can be reached with a modest address sweep. Directed tasks cover the following:
- inclusive limit edges
- the inverted (empty) window
- the enable bit
- alias offsets 0x0FF, 0x100, 0x3FF and 0x400
- a write colliding with a strobe

Sweeps then compare both directions against a model built from the requirements, in several window settings.

// File: rtl/ioWinPkg.sv
package ioWinPkg;

  // Register select codes on the write port.
  typedef enum logic [1:0] {
    SEL_BASE  = 2'd0,
    SEL_LIMIT = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_NONE  = 2'd3
  } cfgSel_e;

  // Bit positions inside the control register write data.
  localparam int unsigned CTRL_IOEN_BIT = 0;
  localparam int unsigned CTRL_ISA_BIT  = 1;

  // Strobes passed from control to datapath each cycle.
  typedef struct packed {
    logic sample;   // a request is present this cycle
    logic upstream; // request direction
    logic winOk;    // limit page is not below base page
    logic ioEn;     // downstream forwarding enabled
    logic isaEn;    // alias filter enabled
  } winCtl_t;

endpackage

// File: rtl/ioWinCtrl.sv
module ioWinCtrl
  import ioWinPkg::*;
#(
  parameter int unsigned PAGE_W = 4,
  parameter int unsigned DATA_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgSel,
  input  logic [DATA_W-1:0] cfgWrData,
  input  logic              reqValid,
  input  logic              reqUpstream,
  output winCtl_t           ctl,
  output logic [PAGE_W-1:0] baseQ,
  output logic [PAGE_W-1:0] limitQ,
  output logic              ioEnQ,
  output logic              isaEnQ
);

  localparam logic [PAGE_W-1:0] BASE_RST  = {PAGE_W{1'b1}};
  localparam logic [PAGE_W-1:0] LIMIT_RST = {PAGE_W{1'b0}};

  logic wrBase, wrLimit, wrCtrl;

  always_comb begin
    wrBase  = cfgWrEn && (cfgSel_e'(cfgSel) == SEL_BASE);
    wrLimit = cfgWrEn && (cfgSel_e'(cfgSel) == SEL_LIMIT);
    wrCtrl  = cfgWrEn && (cfgSel_e'(cfgSel) == SEL_CTRL);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ  <= BASE_RST;
      limitQ <= LIMIT_RST;
      ioEnQ  <= 1'b0;
      isaEnQ <= 1'b0;
    end else begin
      if (wrBase)  baseQ  <= cfgWrData[PAGE_W-1:0];
      if (wrLimit) limitQ <= cfgWrData[PAGE_W-1:0];
      if (wrCtrl) begin
        ioEnQ  <= cfgWrData[CTRL_IOEN_BIT];
        isaEnQ <= cfgWrData[CTRL_ISA_BIT];
      end
    end
  end

  // Strobes use the register values held before any write in this cycle.
  always_comb begin
    ctl.sample   = reqValid;
    ctl.upstream = reqUpstream;
    ctl.winOk    = (limitQ >= baseQ);
    ctl.ioEn     = ioEnQ;
    ctl.isaEn    = isaEnQ;
  end

endmodule

// File: rtl/ioWinDatapath.sv
module ioWinDatapath
  import ioWinPkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned PAGE_W    = 4,
  parameter int unsigned BLK_LSB   = 10,
  parameter int unsigned ISA_SUB_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  winCtl_t           ctl,
  input  logic [PAGE_W-1:0] baseQ,
  input  logic [PAGE_W-1:0] limitQ,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              decValid,
  output logic              decForward
);

  localparam int unsigned PAGE_LSB = ADDR_W - PAGE_W;

  logic [PAGE_W-1:0]    addrPage;
  logic [ISA_SUB_W-1:0] subIdx;
  logic inWindow, isaHole, downClaim, goNext;

  always_comb begin
    addrPage  = reqAddr[ADDR_W-1:PAGE_LSB];
    subIdx    = reqAddr[BLK_LSB-1 -: ISA_SUB_W];
    inWindow  = ctl.winOk && (addrPage >= baseQ) && (addrPage <= limitQ);
    isaHole   = ctl.isaEn && (|subIdx);
    downClaim = ctl.ioEn && inWindow && !isaHole;
    goNext    = ctl.upstream ? !downClaim : downClaim;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decValid   <= 1'b0;
      decForward <= 1'b0;
    end else begin
      decValid   <= ctl.sample;
      decForward <= ctl.sample && goNext;
    end
  end

endmodule

// File: rtl/ioWindowDecoder.sv
module ioWindowDecoder
  import ioWinPkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned PAGE_W    = 4,
  parameter int unsigned BLK_LSB   = 10,
  parameter int unsigned ISA_SUB_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgSel,
  input  logic [PAGE_W-1:0] cfgWrData,
  input  logic              reqValid,
  input  logic              reqUpstream,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              decValid,
  output logic              decForward
);

  winCtl_t           ctl;
  logic [PAGE_W-1:0] cfgBase, cfgLimit;
  logic              cfgIoEn, cfgIsaEn;

  ioWinCtrl #(.PAGE_W(PAGE_W), .DATA_W(PAGE_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgWrData(cfgWrData),
    .reqValid(reqValid), .reqUpstream(reqUpstream),
    .ctl(ctl),
    .baseQ(cfgBase), .limitQ(cfgLimit), .ioEnQ(cfgIoEn), .isaEnQ(cfgIsaEn)
  );

  ioWinDatapath #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BLK_LSB(BLK_LSB), .ISA_SUB_W(ISA_SUB_W)
  ) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .baseQ(cfgBase), .limitQ(cfgLimit), .reqAddr(reqAddr),
    .decValid(decValid), .decForward(decForward)
  );

endmodule

// File: rtl/ioWindowDecoderChk.sv
module ioWindowDecoderChk #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned PAGE_W    = 4,
  parameter int unsigned BLK_LSB   = 10,
  parameter int unsigned ISA_SUB_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqUpstream,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [PAGE_W-1:0] cfgBase,
  input logic [PAGE_W-1:0] cfgLimit,
  input logic              cfgIoEn,
  input logic              cfgIsaEn,
  input logic              decValid,
  input logic              decForward
);

  a_r5_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> decValid);
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!decValid && !decForward));
  a_r3_empty_down: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqUpstream && (cfgLimit < cfgBase)) |=> !decForward);
  a_r3_empty_up: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqUpstream && (cfgLimit < cfgBase)) |=> decForward);
  a_r4_disabled_down: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqUpstream && !cfgIoEn) |=> !decForward);
  a_r7_alias_hole: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqUpstream && cfgIsaEn && (|reqAddr[BLK_LSB-1 -: ISA_SUB_W]))
      |=> !decForward);
  a_r6_below_base: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqUpstream && (reqAddr[ADDR_W-1 -: PAGE_W] < cfgBase))
      |=> !decForward);

endmodule

bind ioWindowDecoder ioWindowDecoderChk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BLK_LSB(BLK_LSB), .ISA_SUB_W(ISA_SUB_W)
) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqUpstream(reqUpstream),
  .reqAddr(reqAddr), .cfgBase(cfgBase), .cfgLimit(cfgLimit),
  .cfgIoEn(cfgIoEn), .cfgIsaEn(cfgIsaEn),
  .decValid(decValid), .decForward(decForward)
);

// File: tb/tb_ioWindowDecoder.sv
`timescale 1ns/1ps
module tb_ioWindowDecoder;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWrEn;
  logic [1:0]  cfgSel;
  logic [3:0]  cfgWrData;
  logic        reqValid;
  logic        reqUpstream;
  logic [15:0] reqAddr;
  logic        decValid, decForward;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // model state mirrored from the writes the bench issues
  logic [3:0] mBase = 4'hF, mLimit = 4'h0;
  logic       mIo = 1'b0, mIsa = 1'b0;

  always #5 clk = ~clk;

  ioWindowDecoder dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgWrData(cfgWrData), .reqValid(reqValid), .reqUpstream(reqUpstream),
    .reqAddr(reqAddr), .decValid(decValid), .decForward(decForward)
  );

  function automatic logic model(input logic [15:0] a, input logic up);
    logic inWin, down;
    inWin = (mLimit >= mBase) && (a[15:12] >= mBase) && (a[15:12] <= mLimit);
    down  = mIo && inWin && !(mIsa && (a[9:8] != 2'b00));
    return up ? !down : down;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] sel, input logic [3:0] data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = sel; cfgWrData = data;
    @(negedge clk);
    cfgWrEn = 1'b0;
    if (sel == 2'd0) mBase = data;
    else if (sel == 2'd1) mLimit = data;
    else if (sel == 2'd2) begin mIo = data[0]; mIsa = data[1]; end
  endtask

  task automatic probe(input string tag, input logic [15:0] a, input logic up,
                       input logic exp);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqUpstream = up;
    @(negedge clk);
    reqValid = 1'b0;
    check({tag, " valid"}, decValid, 1'b1);
    check(tag, decForward, exp);
  endtask

  task automatic testReset();
    check("R1 reset decValid", decValid, 1'b0);
    check("R5 reset decForward", decForward, 1'b0);
    probe("R1 down after reset", 16'h0000, 1'b0, 1'b0);
    probe("R1 down after reset F page", 16'hF123, 1'b0, 1'b0);
    probe("R1 up after reset", 16'h1234, 1'b1, 1'b1);
  endtask

  task automatic testWindow();
    writeReg(2'd0, 4'h2);
    writeReg(2'd1, 4'h5);
    writeReg(2'd2, 4'b0001);
    probe("R6 base edge", 16'h2000, 1'b0, 1'b1);
    probe("R6 limit inclusive xFFF", 16'h5FFF, 1'b0, 1'b1);
    probe("R6 below base", 16'h1FFF, 1'b0, 1'b0);
    probe("R6 above limit", 16'h6000, 1'b0, 1'b0);
    probe("R8 up in window", 16'h3000, 1'b1, 1'b0);
    probe("R8 up outside", 16'h6000, 1'b1, 1'b1);
    @(negedge clk);
    check("R5 idle valid low", decValid, 1'b0);
    check("R5 idle forward low", decForward, 1'b0);
  endtask

  task automatic testIoDisable();
    writeReg(2'd2, 4'b0000);
    probe("R4 disabled down", 16'h3000, 1'b0, 1'b0);
    probe("R4 disabled up", 16'h3000, 1'b1, 1'b1);
    writeReg(2'd2, 4'b0001);
  endtask

  task automatic testEmpty();
    writeReg(2'd0, 4'h6);
    probe("R3 empty down 5", 16'h5000, 1'b0, 1'b0);
    probe("R3 empty down 6", 16'h6000, 1'b0, 1'b0);
    probe("R3 empty up", 16'h5000, 1'b1, 1'b1);
    writeReg(2'd0, 4'h2);
  endtask

  task automatic testIsa();
    writeReg(2'd2, 4'b0011);
    probe("R7 offset 000", 16'h2000, 1'b0, 1'b1);
    probe("R7 offset 0FF", 16'h20FF, 1'b0, 1'b1);
    probe("R7 offset 100", 16'h2100, 1'b0, 1'b0);
    probe("R7 offset 3FF", 16'h23FF, 1'b0, 1'b0);
    probe("R7 offset 400", 16'h2400, 1'b0, 1'b1);
    probe("R7 offset 700", 16'h2700, 1'b0, 1'b0);
    probe("R8 up alias", 16'h2100, 1'b1, 1'b1);
    probe("R8 up low 256", 16'h2050, 1'b1, 1'b0);
    probe("R9 down outside alias", 16'h1100, 1'b0, 1'b0);
    probe("R9 up outside alias", 16'h1100, 1'b1, 1'b1);
    probe("R9 up outside high", 16'h7000, 1'b1, 1'b1);
  endtask

  task automatic testIgnoredSel();
    writeReg(2'd3, 4'hF);
    probe("R2 sel3 isa kept", 16'h2100, 1'b0, 1'b0);
    probe("R2 sel3 base kept", 16'h2000, 1'b0, 1'b1);
    probe("R2 sel3 limit kept", 16'h6000, 1'b0, 1'b0);
  endtask

  task automatic testCollision();
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = 2'd0; cfgWrData = 4'h4;
    reqValid = 1'b1; reqAddr = 16'h2000; reqUpstream = 1'b0;
    @(negedge clk);
    cfgWrEn = 1'b0; reqValid = 1'b0;
    mBase = 4'h4;
    check("R10 same-cycle old base", decForward, 1'b1);
    probe("R10 later new base", 16'h2000, 1'b0, 1'b0);
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < 1024; i++) begin
      for (int d = 0; d < 2; d++) begin
        logic [15:0] a;
        a = 16'(i * 64 + (i % 3) * 21);
        probe(tag, a, d[0], model(a, d[0]));
      end
    end
  endtask

  initial begin
    rstN = 1'b0; cfgWrEn = 1'b0; cfgSel = 2'd0; cfgWrData = 4'h0;
    reqValid = 1'b0; reqUpstream = 1'b0; reqAddr = 16'h0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testWindow();
    testIoDisable();
    testEmpty();
    testIsa();
    testIgnoredSel();
    testCollision();
    writeReg(2'd0, 4'h3); writeReg(2'd1, 4'hC); writeReg(2'd2, 4'b0011);
    sweep("R7 R8 sweep isa on");
    writeReg(2'd2, 4'b0001);
    sweep("R6 R9 sweep isa off");
    writeReg(2'd0, 4'h0); writeReg(2'd1, 4'hF); writeReg(2'd2, 4'b0010);
    sweep("R4 sweep io off");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule